// File: doc/BRIEF.md
# Software-Filled Associative Translation Cache

This block translates virtual page numbers by searching a small, fully associative table. Each slot stores a virtual page number and the page-table entry that belongs to it, together with a valid bit. The number of slots matches the number of physical page frames, so the table always describes every resident page. A lookup compares the requested page number against every valid slot in the same cycle. On a match, the block returns the stored table entry. When no slot matches, the requested page is not resident, and the block raises a page-fault indication.

The hardware never fetches, fills or evicts anything. The fault handler swaps a page into a frame, picks the slot that describes that frame, and rewrites the slot through a write port. The same port can also invalidate a single slot. All results are registered and appear one clock after the request. If a lookup arrives in the same cycle as a write, it is resolved against the table contents from before that write.

Top module: `xlat_cache`

## Requirements
- R1: A lookup request (`lk_req_i` high) that matches a valid slot produces, on the next clock, `rsp_valid_o`=1, `rsp_hit_o`=1 and `rsp_pte_o` equal to the stored table entry of the matching slot. All slots are compared in parallel.
- R2: A lookup that matches no valid slot produces, on the next clock, `rsp_fault_o`=1 and `rsp_hit_o`=0. The table is left unchanged, and later lookups of resident pages still hit.
- R3: Reset clears every valid bit. Until the first write, every lookup faults. While reset is held, all response outputs read 0.
- R4: Every response has exactly one of `rsp_hit_o` and `rsp_fault_o` set. A faulting response returns `rsp_pte_o`=0. In a cycle with no response, `rsp_valid_o`, `rsp_hit_o`, `rsp_fault_o`, `rsp_multi_o` and `rsp_pte_o` are all 0.
- R5: A write (`wr_en_i` high) to slot `wr_idx_i` stores `wr_vpn_i` and `wr_pte_i` and marks the slot valid. Lookups issued from the next cycle onward see the new mapping. The page number that slot held before no longer matches.
- R6: An invalidate (`inv_en_i` high) of slot `inv_idx_i` clears that slot's valid bit, so its page number then faults. Every other slot keeps its mapping.
- R7: When a write and an invalidate name the same slot in the same cycle, the write takes effect and the slot ends up valid with the written contents.
- R8: When more than one valid slot matches, the slot with the lowest index supplies `rsp_pte_o`, and `rsp_multi_o`=1 along with the hit. A response with a single match has `rsp_multi_o`=0.
- R9: A lookup in the same cycle as a write is answered from the contents before the write. A lookup of a slot's old page number still hits with the old table entry. A lookup of the page number being written faults if no other slot holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W (8) | Virtual page number to translate |
| wr_en_i | input | 1 | Slot write strobe |
| wr_idx_i | input | IDX_W (4) | Slot index to write |
| wr_vpn_i | input | VPN_W (8) | Page number to store |
| wr_pte_i | input | PTE_W (16) | Table entry to store |
| inv_en_i | input | 1 | Slot invalidate strobe |
| inv_idx_i | input | IDX_W (4) | Slot index to invalidate |
| rsp_valid_o | output | 1 | Response present (one cycle after a request) |
| rsp_hit_o | output | 1 | Lookup matched a valid slot |
| rsp_fault_o | output | 1 | Page fault: no valid slot matched |
| rsp_multi_o | output | 1 | More than one valid slot matched |
| rsp_pte_o | output | PTE_W (16) | Table entry returned on a hit, zero otherwise |

## Verification
The table is filled with page numbers spread from 0x00 to 0xFF, and every slot is then looked up. This shows that each slot has its own comparator and routes its own payload, and that no slot index is aliased. Absent page numbers, overwritten slots and invalidated slots are looked up next, to separate a missing valid-bit update from a stale comparison. Two slots are given the same page number to check lowest-index priority and the multi-hit flag. Lookups issued in the same cycle as writes show whether the result comes from the old or the new table contents.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   localparam int unsigned DEF_ENTRIES = 16;
   localparam int unsigned DEF_VPN_W   = 8;
   localparam int unsigned DEF_PTE_W   = 16;

   // Output mux style: encoded index mux or one-hot AND-OR mux
   localparam int unsigned SEL_ENCODED = 0;
   localparam int unsigned SEL_ONEHOT  = 1;

   typedef struct packed {
      logic valid;
      logic hit;
      logic fault;
      logic multi;
   } xlat_flags_t;

endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store #(
   parameter int unsigned N     = 16,
   parameter int unsigned VPN_W = 8,
   parameter int unsigned PTE_W = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       wr_en_i,
   input  logic [IDX_W-1:0]           wr_idx_i,
   input  logic [VPN_W-1:0]           wr_vpn_i,
   input  logic [PTE_W-1:0]           wr_pte_i,
   input  logic                       inv_en_i,
   input  logic [IDX_W-1:0]           inv_idx_i,
   output logic [N-1:0]               valid_o,
   output logic [N-1:0][VPN_W-1:0]    vpn_o,
   output logic [N-1:0][PTE_W-1:0]    pte_o
);

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic wr_sel, inv_sel;

      assign wr_sel  = wr_en_i  && (wr_idx_i  == IDX_W'(i));
      assign inv_sel = inv_en_i && (inv_idx_i == IDX_W'(i));

      // A write to the same slot overrides a concurrent invalidate
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            valid_o[i] <= 1'b0;
         end else if (wr_sel) begin
            valid_o[i] <= 1'b1;
         end else if (inv_sel) begin
            valid_o[i] <= 1'b0;
         end
      end

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            vpn_o[i] <= '0;
            pte_o[i] <= '0;
         end else if (wr_sel) begin
            vpn_o[i] <= wr_vpn_i;
            pte_o[i] <= wr_pte_i;
         end
      end
   end

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int unsigned N     = 16,
   parameter int unsigned VPN_W = 8
) (
   input  logic [VPN_W-1:0]           key_i,
   input  logic [N-1:0]               valid_i,
   input  logic [N-1:0][VPN_W-1:0]    vpn_i,
   output logic [N-1:0]               match_o
);

   // One comparator per slot, all evaluated together
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign match_o[i] = valid_i[i] && (vpn_i[i] == key_i);
   end

endmodule

// File: rtl/xlat_select.sv
module xlat_select #(
   parameter int unsigned N         = 16,
   parameter int unsigned PTE_W     = 16,
   parameter int unsigned SEL_STYLE = 0,
   parameter bit          MULTI_DET = 1'b1
) (
   input  logic [N-1:0]               match_i,
   input  logic [N-1:0][PTE_W-1:0]    pte_i,
   output logic                       any_o,
   output logic                       multi_o,
   output logic [PTE_W-1:0]           pte_o
);

   localparam int unsigned SEL_W = (N > 1) ? $clog2(N) : 1;

   assign any_o = |match_i;

   if (MULTI_DET) begin : g_multi
      // Clearing the lowest set bit leaves something only if two or more matched
      assign multi_o = |(match_i & (match_i - 1'b1));
   end else begin : g_no_multi
      assign multi_o = 1'b0;
   end

   if (SEL_STYLE == 0) begin : g_encoded
      logic [SEL_W-1:0] sel;

      always_comb begin
         sel = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (match_i[i]) sel = SEL_W'(i);
         end
      end

      assign pte_o = any_o ? pte_i[sel] : '0;
   end else begin : g_onehot
      logic [N-1:0] lowest;

      assign lowest = match_i & (~match_i + 1'b1);

      always_comb begin
         pte_o = '0;
         for (int i = 0; i < N; i++) begin
            pte_o = pte_o | ({PTE_W{lowest[i]}} & pte_i[i]);
         end
      end
   end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
   parameter int unsigned NUM_ENTRIES = xlat_pkg::DEF_ENTRIES,
   parameter int unsigned VPN_W       = xlat_pkg::DEF_VPN_W,
   parameter int unsigned PTE_W       = xlat_pkg::DEF_PTE_W,
   parameter int unsigned SEL_STYLE   = xlat_pkg::SEL_ENCODED,
   parameter bit          MULTI_DET   = 1'b1,
   localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               lk_req_i,
   input  logic [VPN_W-1:0]   lk_vpn_i,
   input  logic               wr_en_i,
   input  logic [IDX_W-1:0]   wr_idx_i,
   input  logic [VPN_W-1:0]   wr_vpn_i,
   input  logic [PTE_W-1:0]   wr_pte_i,
   input  logic               inv_en_i,
   input  logic [IDX_W-1:0]   inv_idx_i,
   output logic               rsp_valid_o,
   output logic               rsp_hit_o,
   output logic               rsp_fault_o,
   output logic               rsp_multi_o,
   output logic [PTE_W-1:0]   rsp_pte_o
);

   // Elaboration-time parameter checks
   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("xlat_cache: NUM_ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PTE_W < 1) begin : g_bad_width
      $error("xlat_cache: VPN_W and PTE_W must be nonzero");
   end
   if (SEL_STYLE > 1) begin : g_bad_style
      $error("xlat_cache: SEL_STYLE must be 0 or 1");
   end

   logic [NUM_ENTRIES-1:0]              slot_valid;
   logic [NUM_ENTRIES-1:0][VPN_W-1:0]   slot_vpn;
   logic [NUM_ENTRIES-1:0][PTE_W-1:0]   slot_pte;
   logic [NUM_ENTRIES-1:0]              slot_match;
   logic                                any_c, multi_c;
   logic [PTE_W-1:0]                    pte_c;

   xlat_pkg::xlat_flags_t flags_q;
   logic [PTE_W-1:0]      pte_q;

   xlat_entry_store #(
      .N     (NUM_ENTRIES),
      .VPN_W (VPN_W),
      .PTE_W (PTE_W),
      .IDX_W (IDX_W)
   ) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_idx_i  (wr_idx_i),
      .wr_vpn_i  (wr_vpn_i),
      .wr_pte_i  (wr_pte_i),
      .inv_en_i  (inv_en_i),
      .inv_idx_i (inv_idx_i),
      .valid_o   (slot_valid),
      .vpn_o     (slot_vpn),
      .pte_o     (slot_pte)
   );

   xlat_match #(
      .N     (NUM_ENTRIES),
      .VPN_W (VPN_W)
   ) u_match (
      .key_i   (lk_vpn_i),
      .valid_i (slot_valid),
      .vpn_i   (slot_vpn),
      .match_o (slot_match)
   );

   xlat_select #(
      .N         (NUM_ENTRIES),
      .PTE_W     (PTE_W),
      .SEL_STYLE (SEL_STYLE),
      .MULTI_DET (MULTI_DET)
   ) u_select (
      .match_i (slot_match),
      .pte_i   (slot_pte),
      .any_o   (any_c),
      .multi_o (multi_c),
      .pte_o   (pte_c)
   );

   // Response register: the search uses pre-write contents of this cycle
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         flags_q <= '0;
         pte_q   <= '0;
      end else if (lk_req_i) begin
         flags_q.valid <= 1'b1;
         flags_q.hit   <= any_c;
         flags_q.fault <= !any_c;
         flags_q.multi <= any_c && multi_c;
         pte_q         <= any_c ? pte_c : '0;
      end else begin
         flags_q <= '0;
         pte_q   <= '0;
      end
   end

   assign rsp_valid_o = flags_q.valid;
   assign rsp_hit_o   = flags_q.hit;
   assign rsp_fault_o = flags_q.fault;
   assign rsp_multi_o = flags_q.multi;
   assign rsp_pte_o   = pte_q;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int unsigned PTE_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             lk_req_i,
   input logic             wr_en_i,
   input logic             rsp_valid_o,
   input logic             rsp_hit_o,
   input logic             rsp_fault_o,
   input logic             rsp_multi_o,
   input logic [PTE_W-1:0] rsp_pte_o
);

   // Tracks whether any slot has been written since reset
   logic seen_wr_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) seen_wr_q <= 1'b0;
      else         seen_wr_q <= seen_wr_q | wr_en_i;
   end

   assert_rsp_timing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (rsp_valid_o == $past(lk_req_i)));

   assert_hit_xor_fault_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> (rsp_hit_o != rsp_fault_o));

   assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rsp_valid_o |-> (!rsp_hit_o && !rsp_fault_o && !rsp_multi_o && rsp_pte_o == '0));

   assert_fault_zero_pte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_fault_o |-> (rsp_pte_o == '0));

   assert_multi_needs_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_multi_o |-> rsp_hit_o);

   assert_empty_faults_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && rsp_valid_o && !$past(seen_wr_q)) |-> rsp_fault_o);

endmodule

bind xlat_cache xlat_cache_chk #(.PTE_W(PTE_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .lk_req_i    (lk_req_i),
   .wr_en_i     (wr_en_i),
   .rsp_valid_o (rsp_valid_o),
   .rsp_hit_o   (rsp_hit_o),
   .rsp_fault_o (rsp_fault_o),
   .rsp_multi_o (rsp_multi_o),
   .rsp_pte_o   (rsp_pte_o)
);

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;

   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_req;
   logic [7:0]  lk_vpn;
   logic        wr_en;
   logic [3:0]  wr_idx;
   logic [7:0]  wr_vpn;
   logic [15:0] wr_pte;
   logic        inv_en;
   logic [3:0]  inv_idx;
   logic        rsp_valid, rsp_hit, rsp_fault, rsp_multi;
   logic [15:0] rsp_pte;

   int n_tests = 0;
   int n_fail  = 0;

   // captured response
   logic        c_valid, c_hit, c_fault, c_multi;
   logic [15:0] c_pte;

   always #10 clk = ~clk;   // 50 MHz

   xlat_cache dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .lk_req_i    (lk_req),
      .lk_vpn_i    (lk_vpn),
      .wr_en_i     (wr_en),
      .wr_idx_i    (wr_idx),
      .wr_vpn_i    (wr_vpn),
      .wr_pte_i    (wr_pte),
      .inv_en_i    (inv_en),
      .inv_idx_i   (inv_idx),
      .rsp_valid_o (rsp_valid),
      .rsp_hit_o   (rsp_hit),
      .rsp_fault_o (rsp_fault),
      .rsp_multi_o (rsp_multi),
      .rsp_pte_o   (rsp_pte)
   );

   function automatic logic [7:0] vpn_of(int i);
      return 8'(i * 17);
   endfunction

   function automatic logic [15:0] pte_of(int i);
      return 16'(i * 16'h1111) ^ 16'h5A00;
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic capture();
      c_valid = rsp_valid; c_hit = rsp_hit; c_fault = rsp_fault;
      c_multi = rsp_multi; c_pte = rsp_pte;
   endtask

   // Called at a negedge; returns at the next negedge with the response captured
   task automatic do_lookup(input logic [7:0] v);
      lk_req = 1'b1; lk_vpn = v;
      @(negedge clk);
      lk_req = 1'b0;
      capture();
   endtask

   task automatic do_write(input int idx, input logic [7:0] v, input logic [15:0] p);
      wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = v; wr_pte = p;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_inval(input int idx);
      inv_en = 1'b1; inv_idx = 4'(idx);
      @(negedge clk);
      inv_en = 1'b0;
   endtask

   task automatic expect_hit(string req, logic [7:0] v, logic [15:0] p, logic m);
      do_lookup(v);
      check(req, $sformatf("valid vpn %h", v), 32'(c_valid), 32'd1);
      check(req, $sformatf("hit vpn %h", v), 32'(c_hit), 32'd1);
      check(req, $sformatf("pte vpn %h", v), 32'(c_pte), 32'(p));
      check(req, $sformatf("multi vpn %h", v), 32'(c_multi), 32'(m));
   endtask

   task automatic expect_fault(string req, logic [7:0] v);
      do_lookup(v);
      check(req, $sformatf("fault vpn %h", v), 32'(c_fault), 32'd1);
      check(req, $sformatf("no hit vpn %h", v), 32'(c_hit), 32'd0);
      check("R4", $sformatf("zero pte vpn %h", v), 32'(c_pte), 32'd0);
   endtask

   task automatic t_reset();
      check("R3", "valid in reset", 32'(rsp_valid), 32'd0);
      check("R3", "hit in reset", 32'(rsp_hit), 32'd0);
      check("R3", "fault in reset", 32'(rsp_fault), 32'd0);
      check("R3", "pte in reset", 32'(rsp_pte), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_fault("R3", 8'h00);
      expect_fault("R3", 8'h5A);
      expect_fault("R3", 8'hFF);
   endtask

   task automatic t_fill_hit();
      for (int i = 0; i < N; i++) do_write(i, vpn_of(i), pte_of(i));
      for (int i = 0; i < N; i++) expect_hit("R1", vpn_of(i), pte_of(i), 1'b0);
   endtask

   task automatic t_idle();
      do_lookup(vpn_of(1));
      @(negedge clk);
      check("R4", "idle valid", 32'(rsp_valid), 32'd0);
      check("R4", "idle hit", 32'(rsp_hit), 32'd0);
      check("R4", "idle pte", 32'(rsp_pte), 32'd0);
   endtask

   task automatic t_miss();
      expect_fault("R2", 8'h12);
      expect_hit("R2", vpn_of(0), pte_of(0), 1'b0);
      expect_hit("R2", vpn_of(15), pte_of(15), 1'b0);
   endtask

   task automatic t_overwrite();
      do_write(5, 8'hC3, 16'hBEEF);
      expect_fault("R5", vpn_of(5));
      expect_hit("R5", 8'hC3, 16'hBEEF, 1'b0);
   endtask

   task automatic t_invalidate();
      do_inval(7);
      expect_fault("R6", vpn_of(7));
      expect_hit("R6", vpn_of(8), pte_of(8), 1'b0);
      expect_hit("R6", vpn_of(6), pte_of(6), 1'b0);
   endtask

   task automatic t_wr_inv_same();
      wr_en = 1'b1; wr_idx = 4'd7; wr_vpn = 8'h77; wr_pte = 16'h7777;
      inv_en = 1'b1; inv_idx = 4'd7;
      @(negedge clk);
      wr_en = 1'b0; inv_en = 1'b0;
      expect_hit("R7", 8'h77, 16'h7777, 1'b0);
   endtask

   task automatic t_same_cycle();
      // old page number of slot 2 still hits with old payload
      wr_en = 1'b1; wr_idx = 4'd2; wr_vpn = 8'hE1; wr_pte = 16'h1234;
      lk_req = 1'b1; lk_vpn = vpn_of(2);
      @(negedge clk);
      wr_en = 1'b0; lk_req = 1'b0;
      capture();
      check("R9", "old hit", 32'(c_hit), 32'd1);
      check("R9", "old pte", 32'(c_pte), 32'(pte_of(2)));
      expect_hit("R9", 8'hE1, 16'h1234, 1'b0);
      expect_fault("R9", vpn_of(2));
      // new page number being written is not yet visible
      wr_en = 1'b1; wr_idx = 4'd4; wr_vpn = 8'hE4; wr_pte = 16'h4444;
      lk_req = 1'b1; lk_vpn = 8'hE4;
      @(negedge clk);
      wr_en = 1'b0; lk_req = 1'b0;
      capture();
      check("R9", "new vpn faults", 32'(c_fault), 32'd1);
      expect_hit("R9", 8'hE4, 16'h4444, 1'b0);
   endtask

   task automatic t_multi();
      do_write(3, 8'h9A, 16'h3333);
      do_write(12, 8'h9A, 16'hCCCC);
      expect_hit("R8", 8'h9A, 16'h3333, 1'b1);
      do_inval(3);
      expect_hit("R8", 8'h9A, 16'hCCCC, 1'b0);
   endtask

   initial begin
      rst_n = 1'b0; lk_req = 1'b0; lk_vpn = '0;
      wr_en = 1'b0; wr_idx = '0; wr_vpn = '0; wr_pte = '0;
      inv_en = 1'b0; inv_idx = '0;
      repeat (3) @(negedge clk);
      t_reset();
      t_fill_hit();
      t_idle();
      t_miss();
      t_overwrite();
      t_invalidate();
      t_wr_inv_same();
      t_same_cycle();
      t_multi();
      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule